// File: doc/BRIEF.md
# Serial Port Sample Rate Generator

This block turns one selected input clock into the bit clock and the frame strobe of a serial port. Everything runs on one system clock. The input clock is either the system clock itself or one of three external clock lines. The external lines pass through a synchronizer and become single-cycle edge enables, called ticks. A programmable divider counts ticks to form the bit clock (`bclk`). A second counter counts bit-clock cycles to form the frame strobe (`fsync`).

In the free-running mode the frame strobe repeats at a programmed interval. In the locked mode the divider is phase-aligned to an external frame input. Each active transition on that input restarts the divider with the bit clock high and raises the frame strobe at once. The frame interval then follows the external input. This lets the port and an external partner divide the same clock in step. Configuration arrives on plain input ports and is expected to stay steady while reset is low.

Top module: `bitclk_framer`

## Requirements
- R1: While `rst` is high, `bclk` and `fsync` are 0. After reset the frame-input edge detector is armed as if the input had already been active. A frame input that is active during reset and stays active therefore never counts as a transition.
- R2: Source selection: `src_sel`=0 makes every system clock cycle a tick. `src_sel`=1, 2 and 3 take ticks from `ext_clk[0]`, `ext_clk[1]` and `ext_clk[2]`. Lines that are not selected have no effect on `bclk` or `fsync`.
- R3: With an external source, `clk_inv`=0 makes rising edges of the selected line the ticks, and `clk_inv`=1 makes falling edges the ticks. `bclk` changes on the third system clock rising edge after the line changes, and does not change on the opposite edge.
- R4: A bit-clock cycle lasts `div_val`+1 ticks. `bclk` is high for the first ceil((`div_val`+1)/2) ticks of the cycle and low for the rest. With `div_val`=0, `bclk` stays high.
- R5: With `sync_en`=0, the first tick after reset starts a bit-clock cycle and a frame. `fsync` is high for `frm_wid`+1 bit-clock cycles out of every `frm_per`+1, and it rises together with `bclk`.
- R6: With `sync_en`=0, transitions on `ext_frm` have no effect on `bclk` or `fsync`.
- R7: With `sync_en`=1, each inactive-to-active transition of `ext_frm` seen on a tick restarts the divider. `bclk` and `fsync` are both 1 right after that tick. With `src_sel`=0 this happens on the third system clock rising edge after the input changes.
- R8: With `sync_en`=1, after a restart `fsync` stays high for `frm_wid`+1 bit-clock cycles and then stays low until the next transition. `frm_per` is ignored, and an input that is held active does not retrigger.
- R9: With `sync_en`=1 and no transition yet since reset, `bclk` runs freely as in R4 and `fsync` stays 0.
- R10: `frm_inv`=0 makes `ext_frm` active high, and `frm_inv`=1 makes it active low.
- R11: `ext_frm` is sampled only on ticks. A pulse that starts and ends between two ticks is never seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| src_sel | input | 2 | Input clock source: 0 internal, 1 to 3 external line 0 to 2 |
| clk_inv | input | 1 | Tick on falling edges of the external line when 1 |
| frm_inv | input | 1 | External frame input is active low when 1 |
| sync_en | input | 1 | Lock the divider to the external frame input |
| div_val | input | 8 | Bit-clock divide value minus one |
| frm_per | input | 12 | Frame interval in bit-clock cycles, minus one (free mode) |
| frm_wid | input | 8 | Frame strobe width in bit-clock cycles, minus one |
| ext_clk | input | 3 | External clock lines |
| ext_frm | input | 1 | External frame input |
| bclk | output | 1 | Divided bit clock |
| fsync | output | 1 | Frame strobe |

## Verification
The bench drives the frame input in the locked mode at a moment when the free-running count is mid-cycle. A design that only realigns at a cycle boundary, or that restarts with the bit clock low, then produces a bit-clock phase that differs sample by sample from the expected one. It holds the frame input active for many cycles and sets a short programmed interval. A design that retriggers on level, or that still obeys the interval, would pulse the strobe again. It also holds the frame input active through reset and places a short frame pulse between two slow ticks. Either case would produce a false strobe in a design that compares against an unarmed detector or samples the input on every system cycle. Finally, it toggles the lines that are not selected, and the opposite edge of the selected line. A wrong multiplexer or a wrong polarity would add bit-clock flips that the sample-accurate checks catch.

// File: rtl/bitclk_framer.sv
module bitclk_framer #(
  parameter int NEXT  = 3,
  parameter int SEL_W = 2,
  parameter int DIV_W = 8,
  parameter int PER_W = 12,
  parameter int WID_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SEL_W-1:0] src_sel,
  input  logic             clk_inv,
  input  logic             frm_inv,
  input  logic             sync_en,
  input  logic [DIV_W-1:0] div_val,
  input  logic [PER_W-1:0] frm_per,
  input  logic [WID_W-1:0] frm_wid,
  input  logic [NEXT-1:0]  ext_clk,
  input  logic             ext_frm,
  output logic             bclk,
  output logic             fsync
);
  localparam int SPW = DIV_W + 1;

  logic [NEXT-1:0] ck_s1, ck_s2, ck_prev, ck_edge;
  logic frm_s1, frm_s2, frm_prev;
  logic tick, frame_edge, live;
  logic [DIV_W-1:0] cnt, cnt_nx;
  logic [PER_W-1:0] fcnt, fcnt_nx;
  logic [SPW-1:0] span, hi_len;
  logic cyc_end, restart, bclk_nx, fs_nx;

  always_ff @(posedge clk) begin
    if (rst) begin
      ck_s1   <= '0;
      ck_s2   <= '0;
      ck_prev <= '0;
    end else begin
      ck_s1   <= ext_clk ^ {NEXT{clk_inv}};
      ck_s2   <= ck_s1;
      ck_prev <= ck_s2;
    end
  end

  for (genvar i = 0; i < NEXT; i++) begin : g_edge
    assign ck_edge[i] = ck_s2[i] & ~ck_prev[i];
  end

  always_comb begin
    tick = (src_sel == '0);
    for (int i = 0; i < NEXT; i++)
      if (src_sel == SEL_W'(i + 1)) tick = ck_edge[i];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      frm_s1   <= 1'b1;
      frm_s2   <= 1'b1;
      frm_prev <= 1'b1;
    end else begin
      frm_s1 <= ext_frm ^ frm_inv;
      frm_s2 <= frm_s1;
      if (tick) frm_prev <= frm_s2;
    end
  end

  assign frame_edge = tick & sync_en & frm_s2 & ~frm_prev;

  assign span    = {1'b0, div_val} + SPW'(1);
  assign hi_len  = (span + SPW'(1)) >> 1;
  assign cyc_end = (cnt == div_val);
  assign restart = frame_edge | ~live;
  assign cnt_nx  = (restart | cyc_end) ? '0 : cnt + DIV_W'(1);
  assign bclk_nx = ({1'b0, cnt_nx} < hi_len);

  always_comb begin
    fcnt_nx = fcnt;
    if (frame_edge)
      fcnt_nx = '0;
    else if (!live)
      fcnt_nx = sync_en ? '1 : '0;
    else if (cyc_end) begin
      if (sync_en)
        fcnt_nx = (fcnt == '1) ? fcnt : fcnt + PER_W'(1);
      else
        fcnt_nx = (fcnt >= frm_per) ? '0 : fcnt + PER_W'(1);
    end
  end

  assign fs_nx = (fcnt_nx <= PER_W'(frm_wid));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= '0;
      fcnt  <= '0;
      bclk  <= 1'b0;
      fsync <= 1'b0;
      live  <= 1'b0;
    end else if (tick) begin
      cnt   <= cnt_nx;
      fcnt  <= fcnt_nx;
      bclk  <= bclk_nx;
      fsync <= fs_nx;
      live  <= 1'b1;
    end
  end

  // R1
  rst_idle_chk: assert property (@(posedge clk) rst |=> (!bclk && !fsync));

  // R11
  tick_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !tick |=> ($stable(bclk) && $stable(fsync)));

  // R7
  resync_chk: assert property (@(posedge clk) disable iff (rst)
    frame_edge |=> (bclk && fsync));

  // R8
  sync_rise_chk: assert property (@(posedge clk) disable iff (rst)
    (sync_en && $rose(fsync)) |-> $past(frame_edge));

  // R5
  free_align_chk: assert property (@(posedge clk) disable iff (rst)
    (!sync_en && div_val != '0 && $rose(fsync)) |-> $rose(bclk));
endmodule

// File: tb/bitclk_framer_test.sv
module bitclk_framer_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [1:0] src_sel = '0;
  logic clk_inv = 1'b0, frm_inv = 1'b0, sync_en = 1'b0;
  logic [7:0] div_val = '0;
  logic [11:0] frm_per = '0;
  logic [7:0] frm_wid = '0;
  logic [2:0] ext_clk = '0;
  logic ext_frm = 1'b0;
  logic bclk, fsync;
  int nchk = 0, nbad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  bitclk_framer uut (.clk, .rst, .src_sel, .clk_inv, .frm_inv, .sync_en,
    .div_val, .frm_per, .frm_wid, .ext_clk, .ext_frm, .bclk, .fsync);

  task automatic chk(string req, string what, int act, int exp);
    nchk++;
    if (act != exp) begin
      nbad++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int mdl_clk(int k, int d);
    return ((k % (d + 1)) < ((d + 2) / 2)) ? 1 : 0;
  endfunction

  function automatic int mdl_frm(int k, int d, int p, int w);
    return (((k / (d + 1)) % (p + 1)) <= w) ? 1 : 0;
  endfunction

  // Holds reset for three cycles with the given setup (R1 checked there).
  task automatic start(int sel, bit ci, bit fi, bit se, int d, int p, int w, logic frm_lvl);
    rst = 1'b1;
    src_sel = 2'(sel);
    clk_inv = ci;
    frm_inv = fi;
    sync_en = se;
    div_val = 8'(d);
    frm_per = 12'(p);
    frm_wid = 8'(w);
    ext_frm = frm_lvl;
    ext_clk = ci ? 3'b111 : 3'b000;
    repeat (3) @(negedge clk);
    chk("R1", "bclk in reset", int'(bclk), 0);
    chk("R1", "fsync in reset", int'(fsync), 0);
    rst = 1'b0;
  endtask

  // Internal source; frame input goes active at r1 and r2, inactive at f1.
  task automatic run_seq(string req, bit se, bit fi, int d, int p, int w, int n,
                         int r1, int f1, int r2);
    int k0;
    int eb, ef;
    k0 = -1;
    start(0, 1'b0, fi, se, d, p, w, fi);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      if (se && r1 >= 0 && k == r1 + 3) k0 = k;
      if (se && r2 >= 0 && k == r2 + 3) k0 = k;
      if (se) begin
        eb = (k0 >= 0) ? mdl_clk(k - k0, d) : mdl_clk(k, d);
        ef = (k0 >= 0 && ((k - k0) / (d + 1)) <= w) ? 1 : 0;
      end else begin
        eb = mdl_clk(k, d);
        ef = mdl_frm(k, d, p, w);
      end
      chk(req, $sformatf("bclk at tick %0d", k), int'(bclk), eb);
      chk(req, $sformatf("fsync at tick %0d", k), int'(fsync), ef);
      if (k == r1 || k == r2) ext_frm = ~fi;
      if (k == f1) ext_frm = fi;
    end
  endtask

  // R1: frame input active through reset is no transition
  task automatic t_frm_reset();
    start(0, 1'b0, 1'b0, 1'b1, 3, 1, 1, 1'b1);
    for (int k = 0; k < 30; k++) begin
      @(negedge clk);
      chk("R1", "bclk with frame high at reset", int'(bclk), mdl_clk(k, 3));
      chk("R1", "fsync with frame high at reset", int'(fsync), 0);
    end
  endtask

  // R2 / R3: external source, polarity, other lines toggling
  task automatic t_ext(int sel, bit inv);
    logic raw;
    bit act;
    int nt, last;
    raw = inv;
    nt = 0;
    last = 0;
    start(sel, inv, 1'b0, 1'b0, 1, 1, 0, 1'b0);
    for (int h = 0; h < 12; h++) begin
      raw = ~raw;
      ext_clk[sel-1] = raw;
      act = raw ^ inv;
      repeat (2) @(negedge clk);
      chk("R3", "bclk before tick lands", int'(bclk), last);
      for (int i = 0; i < 3; i++)
        if (i != sel - 1) ext_clk[i] = ~ext_clk[i];
      @(negedge clk);
      if (act) begin
        last = (nt % 2 == 0) ? 1 : 0;
        nt++;
      end
      chk("R2", "bclk three cycles after source edge", int'(bclk), last);
      @(negedge clk);
    end
  endtask

  // R11: frame pulse between ticks is missed, one spanning a tick is seen
  task automatic t_frm_sample();
    start(1, 1'b0, 1'b0, 1'b1, 1, 1, 0, 1'b0);
    for (int t = 0; t < 4; t++) begin
      ext_clk[0] = 1'b1;
      repeat (2) @(negedge clk);
      chk("R11", "fsync after short frame pulse", int'(fsync), 0);
      @(negedge clk);
      ext_frm = 1'b1;
      @(negedge clk);
      ext_clk[0] = 1'b0;
      @(negedge clk);
      ext_frm = 1'b0;
      repeat (3) @(negedge clk);
    end
    ext_clk[0] = 1'b1;
    repeat (3) @(negedge clk);
    ext_frm = 1'b1;
    @(negedge clk);
    ext_clk[0] = 1'b0;
    repeat (4) @(negedge clk);
    ext_clk[0] = 1'b1;
    repeat (3) @(negedge clk);
    chk("R11", "fsync after frame held over tick", int'(fsync), 1);
    chk("R11", "bclk after frame held over tick", int'(bclk), 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      nchk++;
      nbad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nbad);
      $finish;
    end
  end

  initial begin
    run_seq("R5", 1'b0, 1'b0, 3, 2, 1, 60, -1, -1, -1);
    run_seq("R4", 1'b0, 1'b0, 4, 3, 0, 60, -1, -1, -1);
    run_seq("R4", 1'b0, 1'b0, 0, 4, 1, 30, -1, -1, -1);
    // R6: frame toggles in free mode change nothing
    run_seq("R6", 1'b0, 1'b0, 2, 2, 0, 50, 10, 20, 30);
    // R7 resync mid-cycle, R8 long pulse and ignored period, R9 before first edge
    run_seq("R7 R8 R9", 1'b1, 1'b0, 3, 1, 1, 75, 10, 40, 50);
    // R10: active-low frame input
    run_seq("R10", 1'b1, 1'b1, 2, 3, 0, 50, 8, 25, 35);
    t_frm_reset();
    t_ext(1, 1'b0);
    t_ext(3, 1'b1);
    t_ext(2, 1'b0);
    t_frm_sample();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nbad);
      $finish;
    end
  end
endmodule